// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a multicycle datapath, built as a microprogram sequencer. A 4-bit microprogram counter selects one word of a built-in control store. Each word holds the full set of datapath strobes and selects for one step of an instruction, plus a 2-bit sequencing field that picks the following microaddress.

The next microaddress comes from one of four sources. It can go back to address 0 to fetch a new instruction. It can be looked up in one of two tables indexed by the 6-bit instruction opcode. It can also be the current address plus one. The first lookup splits instructions by class after decode. The second splits memory reads from memory writes after address computation. The opcode is examined only at the two microaddresses whose sequencing field selects a table.

The control store and both tables are constants computed at elaboration. The read of the store is registered, so the control outputs and the current microaddress leave the block from flip-flops and always belong to the same step.

Top module: `useq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the microaddress at 0. In the first cycle after reset is released, the outputs show the fetch word.
- R2: At microaddresses 0, 3 and 6 (sequencing code 3), the next microaddress is the current one plus one.
- R3: At microaddress 1 (sequencing code 1), the first table is used. Opcode 6'b000000 (register format) goes to 6, 6'b000010 (jump) to 9, 6'b000100 (branch-equal) to 8, and 6'b100011 (load) and 6'b101011 (store) both go to 2.
- R4: At microaddress 2 (sequencing code 2), the second table is used. Load goes to 3 and store goes to 5.
- R5: At microaddresses 4, 5, 7, 8 and 9 (sequencing code 0), the next microaddress is 0.
- R6: An opcode that is absent from the table in use sends the sequence to 0. This applies to both tables.
- R7: The control outputs at each microaddress are as follows; any output not named is 0.
  - 0: mem_rd, ir_wr, pc_wr, src_b=01.
  - 1: src_b=11.
  - 2: src_a, src_b=10.
  - 3: mem_rd, addr_sel.
  - 4: reg_wr, wb_sel.
  - 5: mem_wr, addr_sel.
  - 6: src_a, alu_op=10.
  - 7: reg_wr, dst_sel.
  - 8: src_a, alu_op=01, pc_wr_cond, pc_src=01.
  - 9: pc_wr, pc_src=10.
  - 10 to 15: all outputs 0.
- R8: With the opcode held, an instruction occupies this many cycles from one visit of address 0 to the next: register format 4, load 5, store 4, branch-equal 3, jump 3, unknown opcode 2.
- R9: The opcode has no effect at any microaddress other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write when the ALU reports zero |
| addr_sel | output | 1 | Memory address from the ALU result register (1) or the program counter (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data from the memory data register (1) or the ALU result (0) |
| pc_src | output | 2 | Program-counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU function class: 00 add, 01 subtract, 10 function field |
| src_b | output | 2 | ALU B operand: 00 reg B, 01 constant 4, 10 extended immediate, 11 shifted immediate |
| src_a | output | 1 | ALU A operand: register A (1) or program counter (0) |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination register from the rd field (1) or the rt field (0) |
| uaddr | output | 4 | Current microaddress |

## Verification
Every result is due one clock edge after the opcode it depends on. The opcode present at a rising edge selects the microaddress and control word that appear just after that edge. The bench drives the opcode on the falling edge and advances its reference state machine by one step for each driven opcode. It compares all outputs at the next falling edge, so each comparison falls exactly one register stage after its stimulus. Instruction lengths are measured by counting those falling-edge samples between visits to address 0.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_DISP1 = 2'd1,
    SEQ_DISP2 = 2'd2,
    SEQ_NEXT  = 2'd3
  } seq_sel_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_sel;
    logic [1:0] pc_src;
    logic [1:0] alu_op;
    logic [1:0] src_b;
    logic       src_a;
    logic       reg_wr;
    logic       dst_sel;
  } dp_ctrl_t;

  typedef struct packed {
    dp_ctrl_t   dp;
    logic [1:0] seq;
  } uinstr_t;

  localparam int OPC_RTYPE = 0;
  localparam int OPC_JUMP  = 2;
  localparam int OPC_BEQ   = 4;
  localparam int OPC_LOAD  = 35;
  localparam int OPC_STORE = 43;

  // Dispatch targets; table 1 splits by instruction class, table 2 by memory direction.
  function automatic int disp_target(int tbl, int op);
    int t;
    t = 0;
    if (tbl == 1) begin
      case (op)
        OPC_RTYPE: t = 6;
        OPC_JUMP:  t = 9;
        OPC_BEQ:   t = 8;
        OPC_LOAD:  t = 2;
        OPC_STORE: t = 2;
        default:   t = 0;
      endcase
    end else begin
      case (op)
        OPC_LOAD:  t = 3;
        OPC_STORE: t = 5;
        default:   t = 0;
      endcase
    end
    return t;
  endfunction

  // Microcode contents, one step per address.
  function automatic uinstr_t ucode_entry(int a);
    uinstr_t u;
    u = '0;
    case (a)
      0: begin
        u.dp.mem_rd = 1'b1; u.dp.ir_wr = 1'b1; u.dp.pc_wr = 1'b1;
        u.dp.src_b = 2'b01; u.seq = SEQ_NEXT;
      end
      1: begin
        u.dp.src_b = 2'b11; u.seq = SEQ_DISP1;
      end
      2: begin
        u.dp.src_a = 1'b1; u.dp.src_b = 2'b10; u.seq = SEQ_DISP2;
      end
      3: begin
        u.dp.mem_rd = 1'b1; u.dp.addr_sel = 1'b1; u.seq = SEQ_NEXT;
      end
      4: begin
        u.dp.reg_wr = 1'b1; u.dp.wb_sel = 1'b1; u.seq = SEQ_FETCH;
      end
      5: begin
        u.dp.mem_wr = 1'b1; u.dp.addr_sel = 1'b1; u.seq = SEQ_FETCH;
      end
      6: begin
        u.dp.src_a = 1'b1; u.dp.alu_op = 2'b10; u.seq = SEQ_NEXT;
      end
      7: begin
        u.dp.reg_wr = 1'b1; u.dp.dst_sel = 1'b1; u.seq = SEQ_FETCH;
      end
      8: begin
        u.dp.src_a = 1'b1; u.dp.alu_op = 2'b01; u.dp.pc_wr_cond = 1'b1;
        u.dp.pc_src = 2'b01; u.seq = SEQ_FETCH;
      end
      9: begin
        u.dp.pc_wr = 1'b1; u.dp.pc_src = 2'b10; u.seq = SEQ_FETCH;
      end
      default: u = '0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4,
  parameter int TABLE   = 1
) (
  input  logic [OPC_W-1:0]   opcode,
  output logic [UADDR_W-1:0] target
);
  import useq_pkg::*;

  localparam int ENTRIES = 1 << OPC_W;

  logic [UADDR_W-1:0] tbl [ENTRIES];

  for (genvar o = 0; o < ENTRIES; o++) begin : g_ent
    assign tbl[o] = UADDR_W'(disp_target(TABLE, o));
  end

  assign target = tbl[opcode];

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] upc,
  input  logic [1:0]         seq,
  input  logic [UADDR_W-1:0] disp1,
  input  logic [UADDR_W-1:0] disp2,
  output logic [UADDR_W-1:0] nxt
);
  import useq_pkg::*;

  always_comb begin
    case (seq_sel_e'(seq))
      SEQ_FETCH: nxt = '0;
      SEQ_DISP1: nxt = disp1;
      SEQ_DISP2: nxt = disp2;
      default:   nxt = upc + 1'b1;
    endcase
  end

endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic [UADDR_W-1:0] raddr,
  output useq_pkg::uinstr_t  q
);
  import useq_pkg::*;

  localparam int DEPTH = 1 << UADDR_W;

  uinstr_t rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign rom[a] = ucode_entry(a);
  end

  // Registered read so the store can map onto a block RAM output register.
  always_ff @(posedge clk) begin
    q <= rom[raddr];
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int OPC_W   = 6,
  parameter int UADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPC_W-1:0]   opcode,
  output logic               pc_wr,
  output logic               pc_wr_cond,
  output logic               addr_sel,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_wr,
  output logic               wb_sel,
  output logic [1:0]         pc_src,
  output logic [1:0]         alu_op,
  output logic [1:0]         src_b,
  output logic               src_a,
  output logic               reg_wr,
  output logic               dst_sel,
  output logic [UADDR_W-1:0] uaddr
);
  import useq_pkg::*;

  localparam int N_TABLES = 2;

  logic [UADDR_W-1:0] upc_q;
  logic [UADDR_W-1:0] nxt;
  logic [UADDR_W-1:0] fetch_addr;
  logic [UADDR_W-1:0] disp [N_TABLES];
  uinstr_t            word_q;

  for (genvar t = 0; t < N_TABLES; t++) begin : g_disp
    useq_dispatch #(
      .OPC_W  (OPC_W),
      .UADDR_W(UADDR_W),
      .TABLE  (t + 1)
    ) disp_i (
      .opcode(opcode),
      .target(disp[t])
    );
  end

  useq_next_addr #(.UADDR_W(UADDR_W)) next_i (
    .upc  (upc_q),
    .seq  (word_q.seq),
    .disp1(disp[0]),
    .disp2(disp[1]),
    .nxt  (nxt)
  );

  assign fetch_addr = rst ? '0 : nxt;

  always_ff @(posedge clk) begin
    upc_q <= fetch_addr;
  end

  useq_store #(.UADDR_W(UADDR_W)) store_i (
    .clk  (clk),
    .raddr(fetch_addr),
    .q    (word_q)
  );

  assign pc_wr      = word_q.dp.pc_wr;
  assign pc_wr_cond = word_q.dp.pc_wr_cond;
  assign addr_sel   = word_q.dp.addr_sel;
  assign mem_rd     = word_q.dp.mem_rd;
  assign mem_wr     = word_q.dp.mem_wr;
  assign ir_wr      = word_q.dp.ir_wr;
  assign wb_sel     = word_q.dp.wb_sel;
  assign pc_src     = word_q.dp.pc_src;
  assign alu_op     = word_q.dp.alu_op;
  assign src_b      = word_q.dp.src_b;
  assign src_a      = word_q.dp.src_a;
  assign reg_wr     = word_q.dp.reg_wr;
  assign dst_sel    = word_q.dp.dst_sel;
  assign uaddr      = upc_q;

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk)
    $fell(rst) |-> (uaddr == '0 && mem_rd && ir_wr && pc_wr));

  // R2
  seq_increment_chk: assert property (@(posedge clk) disable iff (rst)
    (word_q.seq == SEQ_NEXT) |=> (uaddr == $past(uaddr) + 1'b1));

  // R5
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (word_q.seq == SEQ_FETCH) |=> (uaddr == '0));

  // R3
  disp1_range_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UADDR_W'(1)) |=> (uaddr == UADDR_W'(0) || uaddr == UADDR_W'(2) ||
                                uaddr == UADDR_W'(6) || uaddr == UADDR_W'(8) ||
                                uaddr == UADDR_W'(9)));

  // R4
  disp2_range_chk: assert property (@(posedge clk) disable iff (rst)
    (uaddr == UADDR_W'(2)) |=> (uaddr == UADDR_W'(0) || uaddr == UADDR_W'(3) ||
                                uaddr == UADDR_W'(5)));

  // R7
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

endmodule

// File: tb/useq_ctrl_tb_top.sv
module useq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
  logic [1:0] pc_src, alu_op, src_b;
  logic       src_a, reg_wr, dst_sel;
  logic [3:0] uaddr;

  int n_cmp  = 0;
  int n_bad  = 0;
  int exp_st = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  useq_ctrl dut_i (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_sel(wb_sel),
    .pc_src(pc_src), .alu_op(alu_op), .src_b(src_b), .src_a(src_a),
    .reg_wr(reg_wr), .dst_sel(dst_sel), .uaddr(uaddr)
  );

  // Order: pc_wr pc_wr_cond addr_sel mem_rd mem_wr ir_wr wb_sel pc_src alu_op src_b src_a reg_wr dst_sel
  function automatic logic [15:0] ref_word(int s);
    case (s)
      0: return 16'b1_0_0_1_0_1_0_00_00_01_0_0_0;
      1: return 16'b0_0_0_0_0_0_0_00_00_11_0_0_0;
      2: return 16'b0_0_0_0_0_0_0_00_00_10_1_0_0;
      3: return 16'b0_0_1_1_0_0_0_00_00_00_0_0_0;
      4: return 16'b0_0_0_0_0_0_1_00_00_00_0_1_0;
      5: return 16'b0_0_1_0_1_0_0_00_00_00_0_0_0;
      6: return 16'b0_0_0_0_0_0_0_00_10_00_1_0_0;
      7: return 16'b0_0_0_0_0_0_0_00_00_00_0_1_1;
      8: return 16'b0_1_0_0_0_0_0_01_01_00_1_0_0;
      9: return 16'b1_0_0_0_0_0_0_10_00_00_0_0_0;
      default: return 16'h0000;
    endcase
  endfunction

  // Reference hardwired next-state function.
  function automatic int ref_next(int s, logic [5:0] op);
    case (s)
      0: return 1;
      1: case (op)
           6'b000000: return 6;
           6'b000010: return 9;
           6'b000100: return 8;
           6'b100011, 6'b101011: return 2;
           default: return 0;
         endcase
      2: case (op)
           6'b100011: return 3;
           6'b101011: return 5;
           default: return 0;
         endcase
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int prev);
    case (prev)
      0, 3, 6: return "R2 R9";
      1:       return "R3 R6";
      2:       return "R4 R6";
      default: return "R5 R9";
    endcase
  endfunction

  function automatic logic [15:0] dut_word();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
            pc_src, alu_op, src_b, src_a, reg_wr, dst_sel};
  endfunction

  task automatic check_state(string tag);
    n_cmp++;
    if (uaddr !== 4'(exp_st)) begin
      n_bad++;
      $display("FAIL %s uaddr actual %0d expected %0d", tag, uaddr, exp_st);
    end
    n_cmp++;
    if (dut_word() !== ref_word(exp_st)) begin
      n_bad++;
      $display("FAIL R7 word at %0d actual %b expected %b", exp_st, dut_word(), ref_word(exp_st));
    end
  endtask

  // Called at a falling edge; result is sampled at the next falling edge.
  task automatic step(logic [5:0] op);
    int prev;
    prev   = exp_st;
    opcode = op;
    exp_st = ref_next(exp_st, op);
    @(negedge clk);
    check_state(tag_of(prev));
  endtask

  // Run one instruction with the opcode held and check its length (R8).
  task automatic run_instr(logic [5:0] op, int len);
    int cyc;
    cyc = 0;
    do begin
      step(op);
      cyc++;
    end while (exp_st != 0 && cyc < 10);
    n_cmp++;
    if (cyc != len) begin
      n_bad++;
      $display("FAIL R8 op %b length actual %0d expected %0d", op, cyc, len);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_st = 0;
    check_state("R1");

    // Directed per-opcode instructions (R3, R4, R5, R8).
    run_instr(6'b000000, 4);
    run_instr(6'b100011, 5);
    run_instr(6'b101011, 4);
    run_instr(6'b000100, 3);
    run_instr(6'b000010, 3);
    run_instr(6'b111111, 2);   // R6 unknown in first table

    // R6: opcode changes to a non-memory code at the second table.
    step(6'b100011);
    step(6'b100011);
    step(6'b000100);
    n_cmp++;
    if (uaddr !== 4'd0) begin
      n_bad++;
      $display("FAIL R6 second table miss actual %0d expected 0", uaddr);
    end

    // R1: reset in the middle of a load.
    step(6'b100011);
    step(6'b100011);
    step(6'b100011);
    rst = 1'b1;
    exp_st = 0;
    @(negedge clk);
    rst = 1'b0;
    check_state("R1");

    // Random opcodes each cycle; R9 covered by changes outside addresses 1 and 2.
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [5:0] op;
      case ($urandom_range(0, 6))
        0: op = 6'b000000;
        1: op = 6'b000010;
        2: op = 6'b000100;
        3: op = 6'b100011;
        4: op = 6'b101011;
        default: op = 6'($urandom);
      endcase
      step(op);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule